// File: doc/BRIEF.md
# Interrupt Status Register Bank

This block gathers hardware interrupt sources into eight status registers that a CPU reaches through a word-addressed port. Writes take one cycle and reads answer combinationally. Each status register holds a four-bit source group in bits [3:0] and a single source in bit 8. The hardware sets a bit according to the register's detection mode: level, rising edge, falling edge or both edges. Software clears a bit by writing a 1 to it.

Six shared control registers decide which status bits raise each register's interrupt and halt lines. Two of them also gate whether two of the level registers capture their inputs at all. A read-only summary word collects five selected register outputs, and their OR is the single top-level interrupt. A separate sticky capture register takes the first nonzero value seen on its input and holds it until software overwrites it.

Top module: `irq_status_bank`

## Requirements
- R1: After reset every status bit, every control register and the sticky value read as zero, and every irq_out, halt_out and top_irq is low.
- R2: The level registers (offsets 0x0, 0x4, 0x8, 0x10, 0x14) set a bit in any cycle its input is high, and keep it set after the input falls.
- R3: The register at 0x20 sets a bit only on a 0-to-1 input change. An input that stays high does not set the bit again after it is cleared.
- R4: The register at 0x30 sets a bit only on a 1-to-0 input change. A rising input leaves the bit clear.
- R5: The register at 0x40 sets a bit on either input change.
- R6: Writing a word to a status register clears exactly the bits written as 1 and leaves the other bits unchanged.
- R7: Bit i of irq_out is the OR of (status AND enable AND NOT mask), and bit i of halt_out is the OR of (status AND halt-enable AND NOT halt-mask). The control words live at 0x100 (enable), 0x104 (mask), 0x108 (halt-enable) and 0x10C (halt-mask). Writing a control word changes these outputs in the cycle after the write and leaves the status bits unchanged.
- R8: The register at 0x10 captures only while bit 0 of the word at 0x110 is 1. The register at 0x14 captures only while bit 1 of the word at 0x114 is 0. Write-1-to-clear still works while capture is blocked.
- R9: The word at 0x50 reads {halt_out[1], irq_out[7], irq_out[6], irq_out[5], irq_out[0]} in bits [4:0]. Writes to it have no effect, and top_irq is the OR of these five bits.
- R10: The sticky word at 0x60 loads its input when the stored value is zero and the input is nonzero, then holds that value. A bus write replaces the stored value, and a write of zero re-arms the load.
- R11: Unmapped offsets read zero and ignore writes. Status bits 7:4 always read zero, and the control words keep only their low 9 bits.
- R12: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| src_wide | input | 8 x WIDE_W | Four-bit source group per status register |
| src_narrow | input | 8 | Single source per status register (bit NARROW_POS) |
| sticky_in | input | STICKY_W | Value offered to the sticky capture register |
| irq_out | output | 8 | Interrupt line of each status register |
| halt_out | output | 8 | Halt line of each status register |
| top_irq | output | 1 | OR of the summary word |

## Verification
The bench builds the bank with its default parameters: a 4-bit group at [3:0], the single source at bit 8, an 8-bit sticky word and a 12-bit address. With these values every offset (status, control up to 0x114, summary and sticky) is an exact decode, and the bits 7:4 between the two fields can be probed for stray set bits. The 8-bit sticky width lets a sequence of distinct nonzero bytes show which value was captured. The 32-bit data path lets writes with all-ones upper bits show that control words truncate to 9 bits.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   typedef enum logic [1:0] {
      DET_LEVEL = 2'd0,
      DET_RISE  = 2'd1,
      DET_FALL  = 2'd2,
      DET_BOTH  = 2'd3
   } det_mode_e;

   typedef enum logic [1:0] {
      GATE_NONE = 2'd0,
      GATE_HIGH = 2'd1,
      GATE_LOW  = 2'd2
   } gate_kind_e;

   localparam int NREG     = 8;
   localparam int NCTL     = 6;
   localparam int NSUM     = 5;

   localparam int CTL_EN   = 0;
   localparam int CTL_MSK  = 1;
   localparam int CTL_HEN  = 2;
   localparam int CTL_HMSK = 3;
   localparam int CTL_WE   = 4;
   localparam int CTL_WEL  = 5;

   localparam int CTL_BASE = 'h100;
   localparam int SUM_OFF  = 'h50;
   localparam int STK_OFF  = 'h60;

   localparam int WE_BIT   = 0;
   localparam int WEL_BIT  = 1;

   function automatic det_mode_e reg_mode(input int idx);
      case (idx)
         5:       return DET_RISE;
         6:       return DET_FALL;
         7:       return DET_BOTH;
         default: return DET_LEVEL;
      endcase
   endfunction

   function automatic gate_kind_e reg_gate(input int idx);
      case (idx)
         3:       return GATE_HIGH;
         4:       return GATE_LOW;
         default: return GATE_NONE;
      endcase
   endfunction

   function automatic int reg_offset(input int idx);
      case (idx)
         0:       return 'h00;
         1:       return 'h04;
         2:       return 'h08;
         3:       return 'h10;
         4:       return 'h14;
         5:       return 'h20;
         6:       return 'h30;
         default: return 'h40;
      endcase
   endfunction

endpackage

// File: rtl/irq_status_cell.sv
module irq_status_cell
   import irq_bank_pkg::*;
#(
   parameter int             W     = 9,
   parameter logic [W-1:0]   VALID = '1,
   parameter det_mode_e      MODE  = DET_LEVEL
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src,
   input  logic         cap_en,
   input  logic [W-1:0] clr,
   input  logic [W-1:0] en,
   input  logic [W-1:0] msk,
   input  logic [W-1:0] hen,
   input  logic [W-1:0] hmsk,
   output logic [W-1:0] status,
   output logic         irq,
   output logic         halt
);

   logic [W-1:0] hit;
   logic [W-1:0] hit_v;

   generate
      if (MODE == DET_LEVEL) begin : g_level
         assign hit = src & {W{cap_en}};
      end else begin : g_edge
         logic [W-1:0] prev;
         always_ff @(posedge clk) begin
            if (!rst_n) prev <= '0;
            else        prev <= src;
         end
         if (MODE == DET_RISE) begin : g_rise
            assign hit = src & ~prev & {W{cap_en}};
            a_r3_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
               ((status & ~$past(status)) & ~$past(src)) == '0);
         end else if (MODE == DET_FALL) begin : g_fall
            assign hit = ~src & prev & {W{cap_en}};
            a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
               ((status & ~$past(status)) & $past(src)) == '0);
         end else begin : g_both
            assign hit = (src ^ prev) & {W{cap_en}};
         end
      end
   endgenerate

   assign hit_v = hit & VALID;

   always_ff @(posedge clk) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr) | hit_v;
   end

   assign irq  = |(status & en  & ~msk);
   assign halt = |(status & hen & ~hmsk);

   a_r6_keep_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status) & ~$past(clr) & ~status) == '0);
   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hit_v) & ~status) == '0);
   a_r8_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> (status & ~$past(status)) == '0);
   a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~VALID) == '0);

endmodule

// File: rtl/irq_sticky_cap.sv
module irq_sticky_cap #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] din,
   output logic [W-1:0] val
);

   logic armed;
   assign armed = (val == '0) && (din != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)     val <= '0;
      else if (wr)    val <= wdata;
      else if (armed) val <= din;
   end

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (val != '0 && !wr) |=> $stable(val));
   a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
      (val == '0 && !wr && din != '0) |=> (val == $past(din)));
   a_r10_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (val == $past(wdata)));

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
   import irq_bank_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int WIDE_W     = 4,
   parameter int NARROW_POS = 8,
   parameter int STICKY_W   = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic                          bus_wr,
   input  logic [DATA_W-1:0]             bus_wdata,
   output logic [DATA_W-1:0]             bus_rdata,
   input  logic [NREG-1:0][WIDE_W-1:0]   src_wide,
   input  logic [NREG-1:0]               src_narrow,
   input  logic [STICKY_W-1:0]           sticky_in,
   output logic [NREG-1:0]               irq_out,
   output logic [NREG-1:0]               halt_out,
   output logic                          top_irq
);

   localparam int STAT_W = NARROW_POS + 1;
   localparam logic [STAT_W-1:0] VALID_M =
      STAT_W'((1 << WIDE_W) - 1) | (STAT_W'(1) << NARROW_POS);

   if (NARROW_POS < WIDE_W) begin : g_bad_layout
      $error("single source bit overlaps the wide group");
   end
   if (DATA_W < STAT_W || DATA_W < STICKY_W || DATA_W < NSUM) begin : g_bad_data
      $error("data path narrower than a register");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("address too narrow for the control block");
   end
   if (STAT_W <= WEL_BIT) begin : g_bad_gate
      $error("gate bit outside control word");
   end

   logic [NCTL-1:0][STAT_W-1:0] ctrl;
   logic [NREG-1:0][STAT_W-1:0] stat;
   logic [NREG-1:0][STAT_W-1:0] src_full;
   logic [NREG-1:0]             cap_en;
   logic [NREG-1:0]             stat_wr;
   logic [NSUM-1:0]             summary;
   logic [STICKY_W-1:0]         sticky_val;
   logic                        sticky_wr;
   logic                        unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata;

   // control words
   generate
      for (genvar c = 0; c < NCTL; c++) begin : g_ctrl
         logic hit_c;
         assign hit_c = bus_wr && (bus_addr == ADDR_W'(CTL_BASE + 4 * c));
         always_ff @(posedge clk) begin
            if (!rst_n)     ctrl[c] <= '0;
            else if (hit_c) ctrl[c] <= bus_wdata[STAT_W-1:0];
         end
      end
   endgenerate

   // status registers, one variant per mode and gate kind
   generate
      for (genvar g = 0; g < NREG; g++) begin : g_stat
         localparam det_mode_e  M  = reg_mode(g);
         localparam gate_kind_e GK = reg_gate(g);

         assign src_full[g] = STAT_W'(src_wide[g]) | (STAT_W'(src_narrow[g]) << NARROW_POS);
         assign stat_wr[g]  = bus_wr && (bus_addr == ADDR_W'(reg_offset(g)));

         if (GK == GATE_HIGH) begin : g_gh
            assign cap_en[g] = ctrl[CTL_WE][WE_BIT];
         end else if (GK == GATE_LOW) begin : g_gl
            assign cap_en[g] = ~ctrl[CTL_WEL][WEL_BIT];
         end else begin : g_gn
            assign cap_en[g] = 1'b1;
         end

         irq_status_cell #(
            .W     (STAT_W),
            .VALID (VALID_M),
            .MODE  (M)
         ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (src_full[g]),
            .cap_en (cap_en[g]),
            .clr    (stat_wr[g] ? bus_wdata[STAT_W-1:0] : '0),
            .en     (ctrl[CTL_EN]),
            .msk    (ctrl[CTL_MSK]),
            .hen    (ctrl[CTL_HEN]),
            .hmsk   (ctrl[CTL_HMSK]),
            .status (stat[g]),
            .irq    (irq_out[g]),
            .halt   (halt_out[g])
         );
      end
   endgenerate

   assign summary = {halt_out[1], irq_out[7], irq_out[6], irq_out[5], irq_out[0]};
   assign top_irq = |summary;

   assign sticky_wr = bus_wr && (bus_addr == ADDR_W'(STK_OFF));

   irq_sticky_cap #(.W(STICKY_W)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (sticky_wr),
      .wdata (bus_wdata[STICKY_W-1:0]),
      .din   (sticky_in),
      .val   (sticky_val)
   );

   // read path, no side effects
   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NREG; i++) begin
         if (bus_addr == ADDR_W'(reg_offset(i))) bus_rdata[STAT_W-1:0] = stat[i];
      end
      for (int c = 0; c < NCTL; c++) begin
         if (bus_addr == ADDR_W'(CTL_BASE + 4 * c)) bus_rdata[STAT_W-1:0] = ctrl[c];
      end
      if (bus_addr == ADDR_W'(SUM_OFF)) bus_rdata[NSUM-1:0] = summary;
      if (bus_addr == ADDR_W'(STK_OFF)) bus_rdata[STICKY_W-1:0] = sticky_val;
   end

   a_r7_ctrl_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr >= ADDR_W'(CTL_BASE)) |=> $stable(stat));
   a_r9_summary_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (top_irq == (irq_out[0] | irq_out[5] | irq_out[6] | irq_out[7] | halt_out[1])));

endmodule

// File: tb/irq_status_bank_tb.sv
module irq_status_bank_tb;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [11:0]     bus_addr = '0;
   logic            bus_wr = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [7:0][3:0] src_wide = '0;
   logic [7:0]      src_narrow = '0;
   logic [7:0]      sticky_in = '0;
   logic [7:0]      irq_out;
   logic [7:0]      halt_out;
   logic            top_irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_status_bank u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .src_wide   (src_wide),
      .src_narrow (src_narrow),
      .sticky_in  (sticky_in),
      .irq_out    (irq_out),
      .halt_out   (halt_out),
      .top_irq    (top_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      #1;
      chk("R1 irq_out", {24'd0, irq_out}, 32'd0);
      chk("R1 halt_out", {24'd0, halt_out}, 32'd0);
      chk("R1 top_irq", {31'd0, top_irq}, 32'd0);
      rd("R1 status0", 12'h000, 32'h0);
      rd("R1 enable", 12'h100, 32'h0);
      rd("R1 sticky", 12'h060, 32'h0);
   endtask

   task automatic t_level;
      @(negedge clk); src_wide[0] = 4'hF;
      @(negedge clk); src_wide[0] = 4'h0;
      rd("R2 level set held", 12'h000, 32'h00F);
      chk("R7 irq0 high", {31'd0, irq_out[0]}, 32'd1);
      wr(12'h000, 32'h3);
      rd("R6 partial clear", 12'h000, 32'h00C);
      wr(12'h000, 32'h0);
      rd("R6 write zero no effect", 12'h000, 32'h00C);
      wr(12'h000, 32'hC);
      rd("R6 full clear", 12'h000, 32'h000);
      #1 chk("R7 irq0 low", {31'd0, irq_out[0]}, 32'd0);
      @(negedge clk); src_narrow[0] = 1'b1;
      wr(12'h000, 32'h100);
      rd("R12 set beats clear", 12'h000, 32'h100);
      @(negedge clk); src_narrow[0] = 1'b0;
      wr(12'h000, 32'h100);
      rd("R2 clear after drop", 12'h000, 32'h000);
   endtask

   task automatic t_ctrl;
      @(negedge clk); src_wide[2] = 4'hF;
      @(negedge clk); src_wide[2] = 4'h0;
      #1;
      chk("R7 irq2 set", {31'd0, irq_out[2]}, 32'd1);
      chk("R7 halt2 set", {31'd0, halt_out[2]}, 32'd1);
      wr(12'h104, 32'hF);
      #1;
      chk("R7 mask irq2", {31'd0, irq_out[2]}, 32'd0);
      chk("R7 halt2 kept", {31'd0, halt_out[2]}, 32'd1);
      rd("R7 status untouched", 12'h008, 32'h00F);
      wr(12'h10C, 32'hF);
      #1 chk("R7 halt-mask halt2", {31'd0, halt_out[2]}, 32'd0);
      wr(12'h104, 32'h0);
      wr(12'h10C, 32'h0);
      #1 chk("R7 unmask irq2", {31'd0, irq_out[2]}, 32'd1);
      wr(12'h100, 32'h0);
      #1 chk("R7 enable off", {31'd0, irq_out[2]}, 32'd0);
      wr(12'h100, 32'h1FF);
      wr(12'h008, 32'h1FF);
      #1 chk("R7 cleared irq2", {31'd0, irq_out[2]}, 32'd0);
   endtask

   task automatic t_gate;
      @(negedge clk); src_wide[3] = 4'hF;
      @(negedge clk); src_wide[3] = 4'h0;
      rd("R8 high gate blocks", 12'h010, 32'h0);
      wr(12'h110, 32'h1);
      @(negedge clk); src_wide[3] = 4'hF;
      @(negedge clk); src_wide[3] = 4'h0;
      rd("R8 high gate passes", 12'h010, 32'h00F);
      wr(12'h110, 32'h0);
      wr(12'h010, 32'h1FF);
      rd("R8 clear while blocked", 12'h010, 32'h0);
      @(negedge clk); src_wide[4] = 4'hF;
      @(negedge clk); src_wide[4] = 4'h0;
      rd("R8 low gate blocks", 12'h014, 32'h0);
      wr(12'h114, 32'h2);
      @(negedge clk); src_wide[4] = 4'hF;
      @(negedge clk); src_wide[4] = 4'h0;
      rd("R8 low gate blocks bit1", 12'h014, 32'h0);
      wr(12'h114, 32'h1);
      @(negedge clk); src_wide[4] = 4'hF;
      @(negedge clk); src_wide[4] = 4'h0;
      rd("R8 low gate passes", 12'h014, 32'h00F);
      wr(12'h114, 32'h3);
      wr(12'h014, 32'h1FF);
      rd("R8 low clear while blocked", 12'h014, 32'h0);
   endtask

   task automatic t_edges;
      @(negedge clk); src_narrow[5] = 1'b1;
      rd("R3 rise sets", 12'h020, 32'h100);
      wr(12'h020, 32'h100);
      tick(2);
      rd("R3 steady high no reset", 12'h020, 32'h0);
      @(negedge clk); src_narrow[5] = 1'b0;
      tick(1);
      rd("R3 fall ignored", 12'h020, 32'h0);
      @(negedge clk); src_narrow[6] = 1'b1;
      tick(1);
      rd("R4 rise ignored", 12'h030, 32'h0);
      @(negedge clk); src_narrow[6] = 1'b0;
      rd("R4 fall sets", 12'h030, 32'h100);
      wr(12'h030, 32'h100);
      rd("R4 cleared", 12'h030, 32'h0);
      @(negedge clk); src_narrow[7] = 1'b1;
      rd("R5 rise sets", 12'h040, 32'h100);
      wr(12'h040, 32'h100);
      rd("R5 cleared", 12'h040, 32'h0);
      @(negedge clk); src_narrow[7] = 1'b0;
      rd("R5 fall sets", 12'h040, 32'h100);
      wr(12'h040, 32'h100);
      rd("R5 cleared again", 12'h040, 32'h0);
   endtask

   task automatic pulse_wide(input int idx);
      @(negedge clk); src_wide[idx] = 4'h1;
      @(negedge clk); src_wide[idx] = 4'h0;
      tick(1);
   endtask

   task automatic t_summary;
      rd("R9 summary idle", 12'h050, 32'h0);
      pulse_wide(0);
      rd("R9 bit0 level", 12'h050, 32'h01);
      #1 chk("R9 top_irq", {31'd0, top_irq}, 32'd1);
      wr(12'h000, 32'h1);
      pulse_wide(5);
      rd("R9 bit1 rise", 12'h050, 32'h02);
      wr(12'h020, 32'h1);
      pulse_wide(6);
      rd("R9 bit2 fall", 12'h050, 32'h04);
      wr(12'h030, 32'h1);
      pulse_wide(7);
      rd("R9 bit3 both", 12'h050, 32'h08);
      wr(12'h040, 32'h1);
      rd("R9 cleared", 12'h050, 32'h0);
      #1 chk("R9 top low", {31'd0, top_irq}, 32'd0);
      wr(12'h108, 32'h0);
      pulse_wide(1);
      rd("R9 halt disabled", 12'h050, 32'h0);
      wr(12'h108, 32'h1);
      rd("R9 bit4 halt", 12'h050, 32'h10);
      wr(12'h050, 32'h0);
      rd("R9 read-only", 12'h050, 32'h10);
      wr(12'h004, 32'h1);
      rd("R9 halt cleared", 12'h050, 32'h0);
   endtask

   task automatic t_sticky;
      @(negedge clk); sticky_in = 8'h12;
      @(negedge clk); sticky_in = 8'h34;
      @(negedge clk); sticky_in = 8'h56;
      rd("R10 first value held", 12'h060, 32'h12);
      wr(12'h060, 32'h0);
      @(negedge clk); sticky_in = 8'h78;
      rd("R10 reload after clear", 12'h060, 32'h56);
      wr(12'h060, 32'h0A);
      rd("R10 write value", 12'h060, 32'h0A);
      @(negedge clk); sticky_in = 8'h00;
      wr(12'h060, 32'h0);
      tick(1);
      rd("R10 zero input stays zero", 12'h060, 32'h0);
   endtask

   task automatic t_unmapped;
      rd("R11 hole reads zero", 12'h00C, 32'h0);
      wr(12'h00C, 32'hFFFF_FFFF);
      rd("R11 hole write ignored", 12'h00C, 32'h0);
      rd("R11 far offset zero", 12'h200, 32'h0);
      @(negedge clk); src_wide[1] = 4'hF; src_narrow[1] = 1'b1;
      @(negedge clk); src_wide[1] = 4'h0; src_narrow[1] = 1'b0;
      rd("R11 bits 7:4 zero", 12'h004, 32'h10F);
      wr(12'h004, 32'hFFFF_FFFF);
      wr(12'h104, 32'hFFFF_FFFF);
      rd("R11 control 9 bits", 12'h104, 32'h1FF);
      wr(12'h104, 32'h0);
   endtask

   initial begin
      tick(4);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      wr(12'h100, 32'h1FF);
      wr(12'h108, 32'h1FF);
      wr(12'h114, 32'h3);
      t_level();
      t_ctrl();
      t_gate();
      t_edges();
      t_summary();
      t_sticky();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule